// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one bus request from an 8-bit processor core into the pin timing of a single machine cycle on an external bus that carries a 16-bit address. The low address byte and the 8-bit data share one set of lines. The core presents a cycle kind, an address and write data for one clock while the sequencer is idle. The sequencer then steps through its T-states. In the first state it pulses an address-latch strobe so that outside logic can capture the low address byte. It then swaps that byte for data, lowers the read or write strobe, and inserts wait states for as long as the addressed device holds ready low. When the cycle ends it reports the captured read data with a one-clock done pulse.

The block supports five kinds of cycle: opcode fetch, memory read, memory write, I/O read and I/O write. Each kind drives its own memory/IO select and status code. An I/O cycle mirrors the 8-bit port number onto the upper address lines. An opcode fetch ends with one extra internal decode state before the bus goes idle. The shared lines are driven only through an output-enable, so an outside tri-state buffer can be attached.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_kind` uses the encoding 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = I/O read, 4 = I/O write. A request with `req_valid` high while idle puts the block in T1 on the next clock. `busy` is high from T1 until the last state of the cycle.
- R2: In T1, `ale`, `ad_oe`, `rd_n` and `wr_n` are all high. `ad_out` carries address bits 7:0. For memory cycles, `addr_hi` carries address bits 15:8.
- R3: `io_sel` is 0 for memory cycles and opcode fetch, and 1 for I/O cycles, from T1 through T3. `stat` is 11 for opcode fetch, 10 for memory and I/O reads, and 01 for memory and I/O writes.
- R4: From T2 through T3, including every wait state, `ale` is low. `rd_n` is low for fetch and read cycles, and `wr_n` is low for write cycles. The two strobes are never low together.
- R5: From T2 through T3, a write cycle drives `req_wdata` on `ad_out` with `ad_oe` high. A fetch or read cycle leaves `ad_oe` low.
- R6: `ready` is sampled only at the end of T2 and at the end of each wait state. A low value there adds one wait state, and a high value moves to T3. `ready` has no effect in any other state.
- R7: In an I/O cycle, address bits 7:0 appear on both `ad_out` in T1 and on `addr_hi`. Address bits 15:8 have no effect.
- R8: For fetch and read cycles, `ad_in` is captured at the clock edge that ends T3. `rsp_done` is high for exactly the one clock that follows T3, and during that clock `rsp_data` holds the captured byte.
- R9: An opcode fetch follows T3 with a T4 state. In T4, `rd_n` and `wr_n` are high, `ad_oe` and `io_sel` are low, `stat` stays 11, `addr_hi` holds its value and `busy` stays high. All other cycles become idle directly after T3.
- R10: While idle, and right after reset, `busy`, `ale`, `ad_oe`, `io_sel`, `stat` and `addr_hi` are all zero, and `rd_n` and `wr_n` are high.
- R11: A request with `req_kind` 5, 6 or 7 is ignored. So is any request made while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the core |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address (port number in bits 7:0 for I/O) |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A machine cycle is in progress |
| ready | input | 1 | Device ready, high means proceed |
| ad_in | input | 8 | Shared lines as read from the pins |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| addr_hi | output | 8 | Upper address lines |
| ale | output | 1 | Address-latch strobe |
| io_sel | output | 1 | Memory (0) or I/O (1) select |
| stat | output | 2 | Cycle status code |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_data | output | 8 | Captured read byte |

## Verification
All pins are registered. T1 therefore appears one clock after a request is accepted, and T2 one clock after that. Each wait state pushes T3 back by exactly one clock, counted from the `ready` value present at the end of T2 or of the wait state before it. The done pulse and the captured byte appear one clock after T3. For an opcode fetch, the bench inserts T4 before idle. For every request the bench builds a queue with one expected pin set per clock, plus the `ready` and `ad_in` values to drive in each clock. It compares each entry half a period after the edge that produced it. Stray requests and `ready` toggles in states that must ignore them are placed in the same queue, so any effect they have appears at the next compared clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4
    } cyc_kind_e;

    localparam logic [2:0] KIND_LAST = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_TW   = 3'd3,
        S_T3   = 3'd4,
        S_T4   = 3'd5
    } tstate_e;

    function automatic logic kind_is_io(cyc_kind_e k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_reads(cyc_kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_writes(cyc_kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic [1:0] kind_status(cyc_kind_e k);
        logic [1:0] s;
        if (k == K_FETCH)      s = 2'b11;
        else if (kind_reads(k)) s = 2'b10;
        else                   s = 2'b01;
        return s;
    endfunction

endpackage

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
    import bcs_pkg::*;
(
    input  tstate_e   state_q,
    input  logic      start,
    input  logic      ready,
    input  cyc_kind_e kind,
    output tstate_e   state_d
);
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:     state_d = start ? S_T1 : S_IDLE;
            S_T1:       state_d = S_T2;
            S_T2, S_TW: state_d = ready ? S_T3 : S_TW;
            S_T3:       state_d = (kind == K_FETCH) ? S_T4 : S_IDLE;
            S_T4:       state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/bcs_pin_decode.sv
module bcs_pin_decode
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  tstate_e           state,
    input  cyc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ale,
    output logic              io_sel,
    output logic [1:0]        stat,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);
    logic [DATA_W-1:0] lo_byte;
    logic [HI_W-1:0]   hi_byte;

    assign lo_byte = addr[DATA_W-1:0];
    assign hi_byte = kind_is_io(kind) ? HI_W'(lo_byte) : addr[ADDR_W-1:DATA_W];

    always_comb begin
        ale     = 1'b0;
        io_sel  = 1'b0;
        stat    = 2'b00;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        addr_hi = '0;
        ad_out  = '0;
        ad_oe   = 1'b0;
        case (state)
            S_T1: begin
                ale     = 1'b1;
                io_sel  = kind_is_io(kind);
                stat    = kind_status(kind);
                addr_hi = hi_byte;
                ad_out  = lo_byte;
                ad_oe   = 1'b1;
            end
            S_T2, S_TW, S_T3: begin
                io_sel  = kind_is_io(kind);
                stat    = kind_status(kind);
                addr_hi = hi_byte;
                rd_n    = ~kind_reads(kind);
                wr_n    = ~kind_writes(kind);
                ad_oe   = kind_writes(kind);
                ad_out  = kind_writes(kind) ? wdata : '0;
            end
            S_T4: begin
                stat    = kind_status(kind);
                addr_hi = hi_byte;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ale,
    output logic              io_sel,
    output logic [1:0]        stat,
    output logic              rd_n,
    output logic              wr_n,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        tstate_e           st;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ale;
        logic              io_sel;
        logic [1:0]        stat;
        logic              rd_n;
        logic              wr_n;
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] ad_out;
        logic              ad_oe;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      start;
    tstate_e   st_next;

    assign start = (r_q.st == S_IDLE) && req_valid && (req_kind <= KIND_LAST);

    bcs_tstate_fsm u_fsm (
        .state_q (r_q.st),
        .start   (start),
        .ready   (ready),
        .kind    (r_q.kind),
        .state_d (st_next)
    );

    cyc_kind_e         kind_n;
    logic [ADDR_W-1:0] addr_n;
    logic [DATA_W-1:0] wdata_n;

    assign kind_n  = start ? cyc_kind_e'(req_kind) : r_q.kind;
    assign addr_n  = start ? req_addr : r_q.addr;
    assign wdata_n = start ? req_wdata : r_q.wdata;

    logic              p_ale, p_io, p_rd_n, p_wr_n, p_oe;
    logic [1:0]        p_stat;
    logic [HI_W-1:0]   p_hi;
    logic [DATA_W-1:0] p_out;

    bcs_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state   (st_next),
        .kind    (kind_n),
        .addr    (addr_n),
        .wdata   (wdata_n),
        .ale     (p_ale),
        .io_sel  (p_io),
        .stat    (p_stat),
        .rd_n    (p_rd_n),
        .wr_n    (p_wr_n),
        .addr_hi (p_hi),
        .ad_out  (p_out),
        .ad_oe   (p_oe)
    );

    always_comb begin
        r_d        = r_q;
        r_d.st     = st_next;
        r_d.kind   = kind_n;
        r_d.addr   = addr_n;
        r_d.wdata  = wdata_n;
        r_d.ale    = p_ale;
        r_d.io_sel = p_io;
        r_d.stat   = p_stat;
        r_d.rd_n   = p_rd_n;
        r_d.wr_n   = p_wr_n;
        r_d.hi     = p_hi;
        r_d.ad_out = p_out;
        r_d.ad_oe  = p_oe;
        r_d.done   = (r_q.st == S_T3);
        if ((r_q.st == S_T3) && kind_reads(r_q.kind)) begin
            r_d.rdata = ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.rd_n <= 1'b1;
            r_q.wr_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != S_IDLE);
    assign ad_out   = r_q.ad_out;
    assign ad_oe    = r_q.ad_oe;
    assign addr_hi  = r_q.hi;
    assign ale      = r_q.ale;
    assign io_sel   = r_q.io_sel;
    assign stat     = r_q.stat;
    assign rd_n     = r_q.rd_n;
    assign wr_n     = r_q.wr_n;
    assign rsp_done = r_q.done;
    assign rsp_data = r_q.rdata;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [DATA_W-1:0] ad_out,
    input logic              ad_oe,
    input logic [HI_W-1:0]   addr_hi,
    input logic              ale,
    input logic              io_sel,
    input logic [1:0]        stat,
    input logic              rd_n,
    input logic              wr_n,
    input logic              rsp_done
);
    a_r1_ale_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> busy);

    a_r2_t1_drives_address: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n));

    a_r3_fetch_is_memory: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 2'b11) |-> !io_sel);

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    a_r4_strobe_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (!rd_n || !wr_n));

    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r7_port_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && io_sel) |-> (HI_W'(ad_out) == addr_hi));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ad_oe && !ale && !io_sel));
endmodule

bind bus_cycle_seq bcs_checker #(.DATA_W(DATA_W), .HI_W(HI_W)) u_bcs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .addr_hi  (addr_hi),
    .ale      (ale),
    .io_sel   (io_sel),
    .stat     (stat),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rsp_done (rsp_done)
);

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        busy, ready = 1'b1;
    logic [7:0]  ad_in = 8'h0;
    logic [7:0]  ad_out, addr_hi, rsp_data;
    logic        ad_oe, ale, io_sel, rd_n, wr_n, rsp_done;
    logic [1:0]  stat;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ready(ready),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .ale(ale), .io_sel(io_sel), .stat(stat), .rd_n(rd_n), .wr_n(wr_n),
        .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    typedef struct {
        logic       ale, io, rd_n, wr_n, oe, busy, done;
        logic [1:0] st;
        logic [7:0] hi, out, rdata;
        bit         chk_out, chk_rdata;
    } exp_t;

    function automatic exp_t idle_e();
        exp_t e;
        e.ale = 0; e.io = 0; e.rd_n = 1; e.wr_n = 1; e.oe = 0; e.busy = 0; e.done = 0;
        e.st = 2'b00; e.hi = 8'h00; e.out = 8'h00; e.rdata = 8'h00;
        e.chk_out = 0; e.chk_rdata = 0;
        return e;
    endfunction

    task automatic chk1(input string req, input string fld, input logic [7:0] act, input logic [7:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, fld, act, expv, $time);
        end
    endtask

    task automatic compare(input exp_t e);
        chk1("R2", "ale", {7'b0, ale}, {7'b0, e.ale});
        chk1("R3", "io_sel", {7'b0, io_sel}, {7'b0, e.io});
        chk1("R3", "stat", {6'b0, stat}, {6'b0, e.st});
        chk1("R4", "rd_n", {7'b0, rd_n}, {7'b0, e.rd_n});
        chk1("R4", "wr_n", {7'b0, wr_n}, {7'b0, e.wr_n});
        chk1("R5", "ad_oe", {7'b0, ad_oe}, {7'b0, e.oe});
        chk1("R7", "addr_hi", addr_hi, e.hi);
        chk1("R1", "busy", {7'b0, busy}, {7'b0, e.busy});
        chk1("R8", "rsp_done", {7'b0, rsp_done}, {7'b0, e.done});
        if (e.chk_out)   chk1("R5", "ad_out", ad_out, e.out);
        if (e.chk_rdata) chk1("R8", "rsp_data", rsp_data, e.rdata);
    endtask

    // One machine cycle: builds the expected per-clock trace, then plays it.
    task automatic op(input logic [2:0] kind, input logic [15:0] addr, input logic [7:0] wd,
                      input int nw, input logic [7:0] rv, input bit stray);
        exp_t       q[$];
        logic       rq[$];
        logic [7:0] aq[$];
        bit         hq[$];
        exp_t       e;
        bit         is_io = (kind == 3'd3) || (kind == 3'd4);
        bit         rd    = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
        bit         wr    = (kind == 3'd2) || (kind == 3'd4);
        logic [1:0] st    = (kind == 3'd0) ? 2'b11 : (rd ? 2'b10 : 2'b01);
        logic [7:0] hi    = is_io ? addr[7:0] : addr[15:8];
        // T1 (R2, R7)
        e = idle_e(); e.ale = 1; e.io = is_io; e.st = st; e.hi = hi; e.oe = 1;
        e.out = addr[7:0]; e.chk_out = 1; e.busy = 1;
        q.push_back(e); rq.push_back(1'b0); aq.push_back(~rv); hq.push_back(stray);
        // T2 and wait states (R4, R5, R6)
        e = idle_e(); e.io = is_io; e.st = st; e.hi = hi; e.rd_n = !rd; e.wr_n = !wr;
        e.oe = wr; e.out = wd; e.chk_out = wr; e.busy = 1;
        for (int k = 0; k <= nw; k++) begin
            q.push_back(e); rq.push_back(k == nw); aq.push_back(~rv); hq.push_back(stray);
        end
        // T3: ready low here must not matter (R6)
        q.push_back(e); rq.push_back(1'b0); aq.push_back(rv); hq.push_back(1'b0);
        // after T3 (R8, R9)
        e = idle_e(); e.done = 1; e.rdata = rv; e.chk_rdata = rd;
        if (kind == 3'd0) begin e.st = 2'b11; e.hi = hi; e.busy = 1; end
        q.push_back(e); rq.push_back(1'b0); aq.push_back(~rv); hq.push_back(1'b0);
        q.push_back(idle_e()); rq.push_back(1'b1); aq.push_back(8'h00); hq.push_back(1'b0);

        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        foreach (q[i]) begin
            @(negedge clk);
            compare(q[i]);
            ready = rq[i];
            ad_in = aq[i];
            if (hq[i]) begin
                // stray request while busy (R11)
                req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'hdead; req_wdata = 8'h77;
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(idle_e());                                 // R10 reset state
        op(3'd0, 16'h12a5, 8'h00, 0, 8'h3c, 1'b0);         // R1 R9 fetch
        op(3'd1, 16'h8001, 8'h00, 2, 8'hc3, 1'b0);         // R6 R8 memory read with waits
        op(3'd2, 16'h4f10, 8'h5a, 0, 8'h00, 1'b0);         // R5 memory write
        op(3'd2, 16'hff7e, 8'ha5, 3, 8'h00, 1'b0);         // R6 write with waits
        op(3'd3, 16'hbe42, 8'h00, 1, 8'h99, 1'b0);         // R7 I/O read
        op(3'd4, 16'h71c8, 8'h0f, 0, 8'h00, 1'b1);         // R7 R11 I/O write with stray request
        op(3'd0, 16'h0000, 8'h00, 1, 8'hff, 1'b1);         // R9 R11 fetch with waits and stray
        for (int k = 5; k < 8; k++) begin                  // R11 reserved kind codes
            @(negedge clk);
            req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h1234;
            @(negedge clk);
            req_valid = 1'b0;
            compare(idle_e());
        end
        op(3'd1, 16'h00ff, 8'h00, 0, 8'h00, 1'b0);         // R8 zero read data
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1 act=hung exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule